// File: doc/BRIEF.md
# Fully Associative Lookup Store with Not-Most-Recently-Used Victim Pointer

This block holds a small set of one-word entries, each tagged with an address tag, and lets a block of memory land in any entry. Every lookup compares the presented tag against all valid entries at the same time, one comparator per entry. It returns a hit flag, the binary index of the matching entry and that entry's data word. The compare path is purely combinational, so the answer is available in the same cycle the tag is presented.

Replacement uses one victim pointer instead of a full recency history. The pointer names the entry that the next miss will overwrite. It steps forward only when the entry it names is used, either by a hit or by being refilled. Because of this rule, the entry just used is never the next victim. On a miss with a valid request, the tag and the fill word offered alongside the request are written into the entry under the pointer at the clock edge. The pointer then advances. After reset, empty entries are consumed in ascending order through the same pointer.

Top module: `fa_nmru_cache`

## Requirements
- R1: After reset, every entry is invalid, `hit` is 0 for any tag, and `victim_idx` is 0.
- R2: A valid request whose tag misses writes `req_tag` and `fill_data` into the entry at `victim_idx` at that clock edge. A later lookup of that tag then hits at that index and returns that data.
- R3: A valid request that misses advances `victim_idx` by one at the clock edge.
- R4: A valid request that hits the entry currently at `victim_idx` advances `victim_idx` by one at the clock edge.
- R5: A valid request that hits any entry other than the one at `victim_idx` leaves `victim_idx` unchanged.
- R6: When `victim_idx` advances from ENTRIES-1, it wraps to 0.
- R7: On a hit, `hit_idx` is the unsigned binary number of the single matching entry and `hit_data` is that entry's stored word. Only valid entries can match, and at most one entry matches any tag.
- R8: While `req_valid` is 0, the contents and `victim_idx` do not change, whatever values `req_tag` and `fill_data` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request qualifier; updates state at the edge |
| req_tag | input | TAG_W | Tag to look up, and to install on a miss |
| fill_data | input | DATA_W | Word installed on a miss |
| hit | output | 1 | Some valid entry holds `req_tag` |
| hit_idx | output | IDX_W | Binary index of the matching entry (0 on miss) |
| hit_data | output | DATA_W | Data of the matching entry (0 on miss) |
| victim_idx | output | IDX_W | Entry the next miss will overwrite |

## Verification
The bench builds the block with 8 entries, 6-bit tags and 8-bit data. This lets it run a tag sequence that fills every entry and wraps the pointer several times within a few hundred cycles. It mixes misses, hits on the pointed entry and hits elsewhere. It also sweeps every possible tag value, so every entry gets refilled and replaced more than once. A small arithmetic model in the bench predicts the hit flag, index, data and pointer at every step.

// File: rtl/fa_nmru_pkg.sv
package fa_nmru_pkg;
   // Next slot for a circular pointer over n entries.
   function automatic int unsigned slot_after(input int unsigned cur, input int unsigned n);
      return (cur == n - 1) ? 0 : cur + 1;
   endfunction
endpackage

// File: rtl/fa_entry_store.sv
module fa_entry_store #(
   parameter int ENTRIES = 64,
   parameter int TAG_W   = 26,
   parameter int DATA_W  = 32,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [TAG_W-1:0]                lookup_tag,
   input  logic                            wr_en,
   input  logic [IDX_W-1:0]                wr_idx,
   input  logic [TAG_W-1:0]                wr_tag,
   input  logic [DATA_W-1:0]               wr_data,
   output logic [ENTRIES-1:0]              match,
   output logic [ENTRIES-1:0][DATA_W-1:0]  words
);
   logic [ENTRIES-1:0]             valid_q;
   logic [ENTRIES-1:0][TAG_W-1:0]  tag_q;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      logic sel;
      assign sel = wr_en && (wr_idx == IDX_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) valid_q[e] <= 1'b0;
         else if (sel) valid_q[e] <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (sel) begin
            tag_q[e] <= wr_tag;
            words[e] <= wr_data;
         end
      end

      assign match[e] = valid_q[e] && (tag_q[e] == lookup_tag);
   end

   AST_MATCH_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match)); // R7
endmodule

// File: rtl/fa_match_encode.sv
module fa_match_encode #(
   parameter int ENTRIES = 64,
   parameter int DATA_W  = 32,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0]              match,
   input  logic [ENTRIES-1:0][DATA_W-1:0]  words,
   output logic                            any,
   output logic [IDX_W-1:0]                idx,
   output logic [DATA_W-1:0]               word
);
   always_comb begin
      idx  = '0;
      word = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (match[e]) begin
            idx  = idx | IDX_W'(e);
            word = word | words[e];
         end
      end
   end
   assign any = |match;
endmodule

// File: rtl/fa_nmru_ptr.sv
module fa_nmru_ptr #(
   parameter int ENTRIES = 64,
   localparam int IDX_W  = $clog2(ENTRIES),
   localparam bit POW2   = (ENTRIES == (1 << IDX_W))
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   output logic [IDX_W-1:0] ptr
);
   logic [IDX_W-1:0] ptr_nx;

   if (POW2) begin : g_pow2
      assign ptr_nx = ptr + 1'b1;
   end else begin : g_wrap
      assign ptr_nx = (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ptr <= '0;
      else if (advance) ptr <= ptr_nx;
   end

   AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      32'(ptr) < ENTRIES); // R6
endmodule

// File: rtl/fa_nmru_cache.sv
module fa_nmru_cache #(
   parameter int ENTRIES = 64,
   parameter int TAG_W   = 26,
   parameter int DATA_W  = 32,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [TAG_W-1:0]  req_tag,
   input  logic [DATA_W-1:0] fill_data,
   output logic              hit,
   output logic [IDX_W-1:0]  hit_idx,
   output logic [DATA_W-1:0] hit_data,
   output logic [IDX_W-1:0]  victim_idx
);
   import fa_nmru_pkg::*;

   initial begin
      assert (ENTRIES >= 2) else $error("ENTRIES must be at least 2");
      assert (TAG_W >= 1 && DATA_W >= 1) else $error("widths must be positive");
   end

   logic [ENTRIES-1:0]             match;
   logic [ENTRIES-1:0][DATA_W-1:0] words;
   logic                           miss_fill;
   logic                           step;

   assign miss_fill = req_valid && !hit;
   assign step      = req_valid && (!hit || hit_idx == victim_idx);

   fa_entry_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .DATA_W(DATA_W)) store_i (
      .clk(clk), .rst_n(rst_n), .lookup_tag(req_tag),
      .wr_en(miss_fill), .wr_idx(victim_idx), .wr_tag(req_tag), .wr_data(fill_data),
      .match(match), .words(words));

   fa_match_encode #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) enc_i (
      .match(match), .words(words), .any(hit), .idx(hit_idx), .word(hit_data));

   fa_nmru_ptr #(.ENTRIES(ENTRIES)) ptr_i (
      .clk(clk), .rst_n(rst_n), .advance(step), .ptr(victim_idx));

   AST_OTHER_HIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && hit && hit_idx != victim_idx) |=> $stable(victim_idx)); // R5
   AST_MISS_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !hit) |=>
         32'(victim_idx) == slot_after(32'($past(victim_idx)), ENTRIES)); // R3
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(victim_idx)); // R8
   AST_MISS_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !hit) |=> (req_tag != $past(req_tag)) || (hit && hit_idx == $past(victim_idx))); // R2
endmodule

// File: tb/fa_nmru_cache_tb_top.sv
module fa_nmru_cache_tb_top;
   localparam int PERIOD = 10;
   localparam int N  = 8;
   localparam int TW = 6;
   localparam int DW = 8;
   localparam int IW = $clog2(N);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [TW-1:0] req_tag = '0;
   logic [DW-1:0] fill_data = '0;
   logic hit;
   logic [IW-1:0] hit_idx;
   logic [DW-1:0] hit_data;
   logic [IW-1:0] victim_idx;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int  m_tag [N];
   int  m_dat [N];
   bit  m_val [N];
   int  m_ptr;

   always #(PERIOD/2) clk = ~clk;

   fa_nmru_cache #(.ENTRIES(N), .TAG_W(TW), .DATA_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tag(req_tag),
      .fill_data(fill_data), .hit(hit), .hit_idx(hit_idx), .hit_data(hit_data),
      .victim_idx(victim_idx));

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int find(input int t);
      for (int e = 0; e < N; e++) if (m_val[e] && m_tag[e] == t) return e;
      return -1;
   endfunction

   task automatic access(input bit v, input int t, input int d);
      int f;
      string preq;
      @(negedge clk);
      req_valid = v;
      req_tag   = TW'(t);
      fill_data = DW'(d);
      #1;
      f = find(t);
      check("R7 hit", int'(hit), int'(f >= 0));
      if (f >= 0) begin
         check("R7 hit_idx", int'(hit_idx), f);
         check("R2 hit_data", int'(hit_data), m_dat[f]);
      end
      @(posedge clk);
      if (!v) preq = "R8 pointer";
      else if (f < 0) begin
         m_tag[m_ptr] = t; m_dat[m_ptr] = d & 8'hff; m_val[m_ptr] = 1'b1;
         preq = (m_ptr == N - 1) ? "R6 pointer" : "R3 pointer";
         m_ptr = (m_ptr + 1) % N;
      end else if (f == m_ptr) begin
         preq = (m_ptr == N - 1) ? "R6 pointer" : "R4 pointer";
         m_ptr = (m_ptr + 1) % N;
      end else preq = "R5 pointer";
      #1;
      check(preq, int'(victim_idx), m_ptr);
   endtask

   initial begin
      #(PERIOD * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int e = 0; e < N; e++) begin m_val[e] = 0; m_tag[e] = 0; m_dat[e] = 0; end
      m_ptr = 0;
      #(PERIOD * 3);
      #1;
      check("R1 victim after reset", int'(victim_idx), 0);
      check("R1 no hit after reset", int'(hit), 0);
      @(negedge clk);
      rst_n = 1'b1;
      // R8: idle cycles with changing inputs before anything is filled
      access(1'b0, 7, 8'h11);
      access(1'b0, 0, 8'h22);
      // R2 R3 R6: fill every entry, wrapping the pointer
      for (int i = 0; i < N; i++) access(1'b1, 10 + i, 8'h40 + i);
      // R4: hit each pointed entry in turn
      for (int i = 0; i < N; i++) access(1'b1, 10 + i, 0);
      // R5: hits away from the pointer
      access(1'b1, 13, 0);
      access(1'b1, 15, 0);
      access(1'b1, 17, 0);
      // R8: idle with a missing tag; it must still miss afterwards
      access(1'b0, 50, 8'h99);
      access(1'b1, 50, 8'h99);
      access(1'b1, 10, 8'h98);
      // near-exhaustive sweep over all tag values, several passes
      for (int p = 0; p < 3; p++)
         for (int t = 0; t < 64; t++) begin
            int tt;
            tt = (t * 5 + p * 3) % 64;
            access(1'b1, tt, (tt * 7 + p) & 8'hff);
            access(1'b1, (tt + 1) % 64, 0);
            if (t % 9 == 0) access(1'b0, tt, 0);
         end
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule